// File: doc/BRIEF.md
# Reversible Gate Self-Test Controller

This block carries a combinational model of a four-in, four-out reversible universal gate and a small sequencer that tests it. A one-cycle `start` pulse launches a run. The sequencer feeds one stored test vector per clock into the gate under test, compares the response with a separate golden copy of the same mapping, and reports at the end of the run whether every response matched. On a failed run it also reports the position of the first vector that mismatched.

Three vector sets are held on chip, and the `mode` input picks one. The unconstrained gate uses a three-vector set that reaches every single stuck-at fault on its primary lines. The half-adder and half-subtractor configurations each use a four-vector set. In those configurations two inputs are tied low, and the vectors keep those inputs at zero.

A fault port can hold any one primary input line or output line of the gate under test at a chosen constant. This makes a detected fault easy to show on demand. The golden copy is never affected by the fault port.

Top module: `rgt_selftest`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `pass` and `fail_idx` are all 0.
- R2: The golden mapping from input {a,b,c,d} (a is the MSB) to output {O1,O2,O3,O4} (O1 is the MSB) is: 0→0, 1→9, 2→2, 3→11, 4→6, 5→15, 6→13, 7→4, 8→14, 9→7, 10→5, 11→12, 12→1, 13→8, 14→3, 15→10. This mapping is a bijection on the 16 codes.
- R3: In mode 0 (full gate), the vectors applied are 0000, 0101 and 1111, at indices 0, 1 and 2. Mode 3 behaves like mode 0.
- R4: In mode 1 (half adder), the vectors applied are 0000, 0100, 1000 and 1100, at indices 0 to 3. With c and d both at 0, O2 equals a XOR b and O4 equals a AND b.
- R5: In mode 2 (half subtractor), the vectors applied are 0000, 0010, 1000 and 1010, at indices 0 to 3.
- R6: When `fault_en` is 0, every run ends with `pass`=1 and `fail_idx`=0, in every mode.
- R7: When `fault_en` is 1, the line named by `fault_line` in the gate under test is held at `fault_val`. Codes 0 to 3 select inputs a, b, c and d. Codes 4 to 7 select outputs O1 to O4. The golden copy is never forced.
- R8: Every stuck-at-0 and stuck-at-1 fault on the eight primary lines makes a mode-0 run end with `pass`=0. `fail_idx` then holds the index of the first vector whose response mismatched.
- R9: A `start` that arrives while `busy` is 1 is ignored. `mode` is sampled only on the clock edge that accepts `start`.
- R10: If N is the size of the selected set, `done` is 1 for exactly one cycle, N clock edges after the edge that accepts `start`. `busy` falls on that same edge. `pass` and `fail_idx` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| mode | input | 2 | Vector set select: 0 full, 1 half adder, 2 half subtractor |
| fault_en | input | 1 | Enables the stuck-at force on the gate under test |
| fault_line | input | 3 | Forced line: 0-3 inputs a-d, 4-7 outputs O1-O4 |
| fault_val | input | 1 | Constant the forced line is held at |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | The last run saw no mismatch |
| fail_idx | output | 2 | Index of the first mismatching vector of the last run |

## Verification
The bench drives all sixteen primary-line faults in full-gate mode. If a line were tied to the wrong bit, the run would pass wrongly or report a wrong first index, because the first failing index of an output fault depends on the golden bit value. It also sends a second `start` with a different mode in the middle of a run. A controller that restarted, or that re-sampled `mode`, would then report `done` at the wrong cycle or with the wrong result. Random runs mix the three modes with faults that may or may not be detectable, checking the results against a bench model. This catches a vector set or a set length that is off by one.

// File: rtl/rgt_pkg.sv
package rgt_pkg;

  localparam int GATE_W = 4;

  typedef enum logic [1:0] {
    SET_FULL = 2'd0,
    SET_HADD = 2'd1,
    SET_HSUB = 2'd2,
    SET_ALT  = 2'd3
  } vec_set_e;

  function automatic logic [GATE_W-1:0] gate_fn(input logic [GATE_W-1:0] x);
    logic [GATE_W-1:0] y;
    case (x)
      4'd0:  y = 4'd0;
      4'd1:  y = 4'd9;
      4'd2:  y = 4'd2;
      4'd3:  y = 4'd11;
      4'd4:  y = 4'd6;
      4'd5:  y = 4'd15;
      4'd6:  y = 4'd13;
      4'd7:  y = 4'd4;
      4'd8:  y = 4'd14;
      4'd9:  y = 4'd7;
      4'd10: y = 4'd5;
      4'd11: y = 4'd12;
      4'd12: y = 4'd1;
      4'd13: y = 4'd8;
      4'd14: y = 4'd3;
      default: y = 4'd10;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/rgt_gate.sv
module rgt_gate
  import rgt_pkg::*;
(
  input  logic [GATE_W-1:0] x,
  output logic [GATE_W-1:0] y
);

  always_comb y = gate_fn(x);

  // R2: the mapping must be a bijection over all input codes
  initial begin : a_r2_bijective
    logic [(1<<GATE_W)-1:0] hit;
    hit = '0;
    for (int i = 0; i < (1 << GATE_W); i++) hit[gate_fn(GATE_W'(i))] = 1'b1;
    a_r2_all_codes_hit: assert (&hit);
  end

  // R4: half-adder use, c=d=0 gives sum on O2 and carry on O4
  always_comb begin
    if (x[1:0] == 2'b00) begin
      a_r4_half_adder: assert (y[2] == (x[3] ^ x[2]) && y[0] == (x[3] & x[2]));
    end
  end

endmodule

// File: rtl/rgt_fault_inj.sv
module rgt_fault_inj #(
  parameter int W     = 4,
  parameter int SEL_W = 2
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             val,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q
);

  // sel counts from the MSB: sel 0 forces bit W-1
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign q[g] = (en && sel == SEL_W'(W - 1 - g)) ? val : d[g];
  end

endmodule

// File: rtl/rgt_vec_rom.sv
module rgt_vec_rom
  import rgt_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  vec_set_e          set,
  input  logic [IDX_W-1:0]  idx,
  output logic [GATE_W-1:0] vec,
  output logic [IDX_W-1:0]  last
);

  localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(2);
  localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(3);

  always_comb begin
    vec  = '0;
    last = LAST_FULL;
    case (set)
      SET_HADD: begin
        last = LAST_HALF;
        vec  = {idx[1], idx[0], 2'b00};
      end
      SET_HSUB: begin
        last = LAST_HALF;
        vec  = {idx[1], 1'b0, idx[0], 1'b0};
      end
      default: begin
        case (idx)
          IDX_W'(0): vec = 4'b0000;
          IDX_W'(1): vec = 4'b0101;
          default:   vec = 4'b1111;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/rgt_selftest.sv
module rgt_selftest
  import rgt_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              fault_en,
  input  logic [LINE_W-1:0] fault_line,
  input  logic              fault_val,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [IDX_W-1:0]  fail_idx
);

  localparam int SEL_W = LINE_W - 1;

  vec_set_e          set_q;
  logic              busy_q, done_q, pass_q, seen_q;
  logic [IDX_W-1:0]  idx_q, fidx_q, fail_q, last_idx;
  logic [GATE_W-1:0] vec, gold, gut_in, gut_raw, gut_out;
  logic              mismatch;

  rgt_vec_rom #(.IDX_W(IDX_W)) u_rom (
    .set(set_q), .idx(idx_q), .vec(vec), .last(last_idx)
  );

  rgt_gate u_gold (.x(vec), .y(gold));

  rgt_fault_inj #(.W(GATE_W), .SEL_W(SEL_W)) u_fin (
    .en(fault_en && !fault_line[LINE_W-1]), .sel(fault_line[SEL_W-1:0]),
    .val(fault_val), .d(vec), .q(gut_in)
  );

  rgt_gate u_gut (.x(gut_in), .y(gut_raw));

  rgt_fault_inj #(.W(GATE_W), .SEL_W(SEL_W)) u_fout (
    .en(fault_en && fault_line[LINE_W-1]), .sel(fault_line[SEL_W-1:0]),
    .val(fault_val), .d(gut_raw), .q(gut_out)
  );

  assign mismatch = busy_q && (gut_out != gold);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      seen_q <= 1'b0;
      idx_q  <= '0;
      fidx_q <= '0;
      fail_q <= '0;
      set_q  <= SET_FULL;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          seen_q <= 1'b0;
          fidx_q <= '0;
          set_q  <= vec_set_e'(mode);
        end
      end else begin
        if (mismatch && !seen_q) begin
          seen_q <= 1'b1;
          fidx_q <= idx_q;
        end
        if (idx_q == last_idx) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pass_q <= !(seen_q || mismatch);
          fail_q <= seen_q ? fidx_q : (mismatch ? idx_q : '0);
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign pass     = pass_q;
  assign fail_idx = fail_q;

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R10: busy has dropped when done shows
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R9: selected set holds for a whole run
  a_r9_set_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(set_q));
  // R9: a start during a run does not rewind the index
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && idx_q != last_idx) |=> (busy_q && idx_q == $past(idx_q) + 1'b1));
  // R7: with injection off the two gate copies agree
  a_r7_clean_path: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !fault_en) |-> (gut_out == gold));

endmodule

// File: tb/rgt_selftest_test.sv
module rgt_selftest_test;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       fault_en = 1'b0;
  logic [2:0] fault_line = 3'd0;
  logic       fault_val = 1'b0;
  logic       busy, done, pass;
  logic [1:0] fail_idx;

  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rgt_selftest uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .fault_en(fault_en), .fault_line(fault_line), .fault_val(fault_val),
    .busy(busy), .done(done), .pass(pass), .fail_idx(fail_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_map(input logic [3:0] v);
    logic [3:0] t [16];
    t = '{4'd0, 4'd9, 4'd2, 4'd11, 4'd6, 4'd15, 4'd13, 4'd4,
          4'd14, 4'd7, 4'd5, 4'd12, 4'd1, 4'd8, 4'd3, 4'd10};
    return t[v];
  endfunction

  function automatic int ref_len(input logic [1:0] m);
    return (m == 2'd1 || m == 2'd2) ? 4 : 3;
  endfunction

  function automatic logic [3:0] ref_vec(input logic [1:0] m, input int i);
    logic [1:0] b;
    b = 2'(i);
    if (m == 2'd1) return {b[1], b[0], 2'b00};
    if (m == 2'd2) return {b[1], 1'b0, b[0], 1'b0};
    if (i == 0) return 4'b0000;
    if (i == 1) return 4'b0101;
    return 4'b1111;
  endfunction

  function automatic logic [3:0] ref_gut(input logic [3:0] v, input bit fe,
                                          input logic [2:0] fl, input bit fv);
    logic [3:0] x, y;
    x = v;
    if (fe && !fl[2]) x[3 - fl[1:0]] = fv;
    y = ref_map(x);
    if (fe && fl[2]) y[3 - fl[1:0]] = fv;
    return y;
  endfunction

  // R8/R6 model: pass flag and first failing index
  task automatic ref_run(input logic [1:0] m, input bit fe, input logic [2:0] fl,
                         input bit fv, output bit p, output int fi);
    p = 1'b1;
    fi = 0;
    for (int i = 0; i < ref_len(m); i++) begin
      if (p && ref_gut(ref_vec(m, i), fe, fl, fv) != ref_map(ref_vec(m, i))) begin
        p = 1'b0;
        fi = i;
      end
    end
  endtask

  task automatic run(input logic [1:0] m, input bit fe, input logic [2:0] fl,
                     input bit fv, input bit disturb, input string req);
    bit ep;
    int ei, k;
    ref_run(m, fe, fl, fv, ep, ei);
    @(negedge clk);
    fault_en = fe; fault_line = fl; fault_val = fv;
    mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < 12) begin
      if (disturb && k == 0) begin
        start = 1'b1;
        mode = (m == 2'd0) ? 2'd1 : 2'd0;
      end
      @(negedge clk);
      start = 1'b0;
      k++;
      if (done) break;
    end
    chk(done && k == ref_len(m), {req, " R10 done timing"}, k, ref_len(m));
    chk(pass == ep, {req, " pass"}, int'(pass), int'(ep));
    chk(int'(fail_idx) == ei, {req, " fail_idx"}, int'(fail_idx), ei);
    @(negedge clk);
    chk(!done && !busy, {req, " R10 pulse end"}, int'(done), 0);
    chk(pass == ep, {req, " R10 result held"}, int'(pass), int'(ep));
  endtask

  initial begin : wdog
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !pass && fail_idx == 2'd0, "R1 reset state",
        int'({busy, done, pass, fail_idx}), 0);

    begin : r2_bij
      logic [15:0] hit;
      hit = '0;
      for (int i = 0; i < 16; i++) hit[ref_map(4'(i))] = 1'b1;
      chk(&hit, "R2 reference bijection", int'(hit), 16'hFFFF);
    end

    // R6: fault-free in every mode, including the alias mode
    for (int m = 0; m < 4; m++) run(2'(m), 1'b0, 3'd0, 1'b0, 1'b0, "R6 clean R3 R4 R5");

    // R8 R7: all primary-line faults, full set
    for (int l = 0; l < 8; l++)
      for (int v = 0; v < 2; v++)
        run(2'd0, 1'b1, 3'(l), 1'(v), 1'b0, "R8 full-set fault");

    // R4 R5: tied-input faults in half modes (undetected per model)
    run(2'd1, 1'b1, 3'd2, 1'b0, 1'b0, "R4 c stuck 0");
    run(2'd2, 1'b1, 3'd1, 1'b0, 1'b0, "R5 b stuck 0");
    run(2'd1, 1'b1, 3'd5, 1'b1, 1'b0, "R4 sum stuck 1");

    // R9: second start and mode change mid-run are ignored
    run(2'd0, 1'b0, 3'd0, 1'b0, 1'b1, "R9 busy start full");
    run(2'd2, 1'b1, 3'd0, 1'b1, 1'b1, "R9 busy start hsub");
    run(2'd1, 1'b1, 3'd7, 1'b1, 1'b1, "R9 busy start hadd");

    // random mix
    for (int n = 0; n < 60; n++)
      run(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R7 random");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule